// File: doc/BRIEF.md
# Watermark-gated round-robin burst write arbiter

This block collects data from several independent input streams and forwards it, one whole burst at a time, to a single burst-write port that leads to shared memory. Each input stream owns a small buffer that keeps taking data while the stream waits for its turn. A stream becomes a candidate for the output port only when its buffer holds at least one full burst, so every memory access the block issues has the full configured length.

A rotating scheduler picks the next candidate by channel index. The search starts at the channel after the one served last, so under full load every channel gets a turn. The chosen channel keeps the port until its final beat, which carries a last flag, has been accepted. Each channel writes into its own region of memory, which is given by a base address. A per-channel write offset steps forward by one burst's worth of bytes after each burst and returns to zero at the end of a programmable region size.

The burst length, which also serves as the request watermark, and the region size are captured when a burst is granted. Changing them while a burst is in progress affects only later bursts.

Top module: `wm_burst_arb`

## Requirements
- R1: After reset the output is idle (out_valid low), every buffer is empty (all in_ready high), every write offset is zero and the rotating search starts at channel 0.
- R2: A channel whose buffer holds fewer words than cfg_burst_len is never granted, and the output stays idle while no channel qualifies. A cfg_burst_len of zero disables all requests.
- R3: A burst carries exactly the number of beats held in cfg_burst_len at grant time. The beats come from one channel's buffer in arrival order, and out_last is high on the final beat only.
- R4: out_chan gives the index of the granted channel and stays constant for the whole burst. No other channel's data appears on the output until the last beat of the burst has been accepted.
- R5: While out_valid is high and out_ready is low, out_data, out_last, out_addr and out_chan hold their values and out_valid stays high.
- R6: out_addr equals the channel's base (cfg_base slice ch*AW) plus that channel's write offset, and it is constant within the burst. After each burst the offset grows by burst length times DW/8 bytes. If the result is equal to or greater than the region size captured at grant time, the offset returns to zero.
- R7: After channel g is served, the next grant goes to the first qualifying channel found when scanning from index g+1 upward, wrapping past NCH-1 to 0. When all channels qualify, the grants cycle through the indices in order.
- R8: Changes to cfg_burst_len or cfg_region_bytes made after a grant do not alter that burst's length or its offset update. They apply from the next grant.
- R9: in_ready of a channel is low while its buffer holds DEPTH words. A word offered in that state is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NCH | Per-channel input word strobe |
| in_ready | output | NCH | Per-channel buffer not full |
| in_data | input | NCH*DW | Per-channel input words, channel c at bits c*DW upward |
| cfg_burst_len | input | $clog2(MAX_BURST+1) | Beats per burst and request watermark; 0 disables |
| cfg_region_bytes | input | AW | Size of each channel's memory region in bytes |
| cfg_base | input | NCH*AW | Per-channel region base address, channel c at bits c*AW upward |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat accepted when high with out_valid |
| out_data | output | DW | Output beat data |
| out_last | output | 1 | Final beat of the burst |
| out_addr | output | AW | Start address of the current burst |
| out_chan | output | $clog2(NCH) | Index of the granted channel |

## Verification
A corrupted beat counter shows up inside the same burst: out_last appears on the wrong beat, or a stale or foreign word appears before the port is released. A wrong rotation pointer is only visible at the next grant, where out_chan names a channel other than the next one in index order. A wrong write offset stays hidden until that same channel is granted again, where its first beat shows a wrong out_addr. For that reason the bench serves every channel several times and drives the offset through a wrap before it compares addresses.

// File: rtl/wba_pkg.sv
package wba_pkg;
  typedef enum logic [0:0] {
    ARB_IDLE  = 1'b0,
    ARB_BURST = 1'b1
  } arb_state_t;
endpackage

// File: rtl/wba_fifo.sv
// Per-channel synchronous buffer with a fill-level output.
module wba_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [LW-1:0] level,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign do_push = push && (cnt != LW'(DEPTH));
  assign do_pop  = pop && (cnt != '0);

  // storage: no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign pop_data = mem[rd_ptr];
  assign level    = cnt;
  assign full     = (cnt == LW'(DEPTH));
endmodule

// File: rtl/wba_rr_pick.sv
// Rotating-priority search: first set request at or after 'start'.
module wba_rr_pick #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  input  logic [CW-1:0]  start,
  output logic           found,
  output logic [CW-1:0]  idx
);
  int j;
  always_comb begin
    found = 1'b0;
    idx   = '0;
    j     = 0;
    for (int k = 0; k < NCH; k++) begin
      j = int'(start) + k;
      if (j >= NCH) j = j - NCH;
      if (!found && req[j]) begin
        found = 1'b1;
        idx   = CW'(j);
      end
    end
  end
endmodule

// File: rtl/wba_addr_gen.sv
// Per-channel write offsets, advanced once per completed burst.
module wba_addr_gen #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] look_ch,
  output logic [AW-1:0] look_ptr,
  input  logic          adv,
  input  logic [CW-1:0] adv_ch,
  input  logic [AW-1:0] adv_step,
  input  logic [AW-1:0] adv_region
);
  logic [AW-1:0] wptr [NCH];
  logic [AW-1:0] nxt;

  assign nxt      = wptr[adv_ch] + adv_step;
  assign look_ptr = wptr[look_ch];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) wptr[c] <= '0;
    end else if (adv) begin
      wptr[adv_ch] <= (nxt >= adv_region) ? '0 : nxt;
    end
  end
endmodule

// File: rtl/wm_burst_arb.sv
module wm_burst_arb #(
  parameter int NCH       = 4,
  parameter int DW        = 32,
  parameter int AW        = 32,
  parameter int DEPTH     = 16,
  parameter int MAX_BURST = 8,
  localparam int CW       = $clog2(NCH),
  localparam int LW       = $clog2(DEPTH + 1),
  localparam int BLW      = $clog2(MAX_BURST + 1),
  localparam int BPB      = DW / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    in_valid,
  output logic [NCH-1:0]    in_ready,
  input  logic [NCH*DW-1:0] in_data,
  input  logic [BLW-1:0]    cfg_burst_len,
  input  logic [AW-1:0]     cfg_region_bytes,
  input  logic [NCH*AW-1:0] cfg_base,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_last,
  output logic [AW-1:0]     out_addr,
  output logic [CW-1:0]     out_chan
);
  import wba_pkg::*;

  arb_state_t     state_q;
  logic [CW-1:0]  grant_q, rr_q;
  logic [BLW-1:0] beats_left_q, bl_q;
  logic [AW-1:0]  region_q, addr_q;

  logic [LW-1:0]  level_w [NCH];
  logic [DW-1:0]  pop_data_w [NCH];
  logic [NCH-1:0] full_w, pop_w, req_w;
  logic           found_w, load, burst_done;
  logic [CW-1:0]  pick_idx;
  logic [AW-1:0]  look_ptr, base_sel, step;

  assign load = (state_q == ARB_BURST) && (beats_left_q != '0) && (!out_valid || out_ready);
  assign burst_done = (state_q == ARB_BURST) && out_valid && out_ready && out_last;

  // per-channel buffers and request qualification
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wba_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
      .clk       (clk),
      .rst       (rst),
      .push      (in_valid[g]),
      .push_data (in_data[g*DW +: DW]),
      .pop       (pop_w[g]),
      .pop_data  (pop_data_w[g]),
      .level     (level_w[g]),
      .full      (full_w[g])
    );
    assign in_ready[g] = !full_w[g];
    assign pop_w[g]    = load && (grant_q == CW'(g));
    assign req_w[g]    = (cfg_burst_len != '0) && (level_w[g] >= LW'(cfg_burst_len));
  end

  wba_rr_pick #(.NCH(NCH)) u_pick (
    .req   (req_w),
    .start (rr_q),
    .found (found_w),
    .idx   (pick_idx)
  );

  assign step     = AW'(bl_q) * AW'(BPB);
  assign base_sel = cfg_base[pick_idx*AW +: AW];

  wba_addr_gen #(.NCH(NCH), .AW(AW)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .look_ch    (pick_idx),
    .look_ptr   (look_ptr),
    .adv        (burst_done),
    .adv_ch     (grant_q),
    .adv_step   (step),
    .adv_region (region_q)
  );

  // grant state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ARB_IDLE;
      grant_q      <= '0;
      rr_q         <= '0;
      beats_left_q <= '0;
      bl_q         <= '0;
      region_q     <= '0;
      addr_q       <= '0;
    end else begin
      case (state_q)
        ARB_IDLE: begin
          if (found_w) begin
            grant_q      <= pick_idx;
            bl_q         <= cfg_burst_len;
            beats_left_q <= cfg_burst_len;
            region_q     <= cfg_region_bytes;
            addr_q       <= base_sel + look_ptr;
            state_q      <= ARB_BURST;
          end
        end
        default: begin
          if (load) beats_left_q <= beats_left_q - 1'b1;
          if (burst_done) begin
            rr_q    <= (grant_q == CW'(NCH - 1)) ? '0 : grant_q + 1'b1;
            state_q <= ARB_IDLE;
          end
        end
      endcase
    end
  end

  // registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      out_addr  <= '0;
      out_chan  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= pop_data_w[grant_q];
      out_last  <= (beats_left_q == BLW'(1));
      out_addr  <= addr_q;
      out_chan  <= grant_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wba_checker.sv
module wba_checker #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_last,
  input logic [AW-1:0] out_addr,
  input logic [CW-1:0] out_chan
);
  logic          in_burst_q;
  logic [CW-1:0] chan_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_burst_q <= 1'b0;
      chan_q     <= '0;
      addr_q     <= '0;
    end else if (out_valid && out_ready) begin
      in_burst_q <= !out_last;
      chan_q     <= out_chan;
      addr_q     <= out_addr;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !out_valid);

  a_r5_stall_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)
                                   && $stable(out_addr) && $stable(out_chan)));

  a_r4_chan_held: assert property (@(posedge clk) disable iff (rst)
    (in_burst_q && out_valid) |-> (out_chan == chan_q));

  a_r6_addr_held: assert property (@(posedge clk) disable iff (rst)
    (in_burst_q && out_valid) |-> (out_addr == addr_q));
endmodule

bind wm_burst_arb wba_checker #(.DW(DW), .AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .out_addr  (out_addr),
  .out_chan  (out_chan)
);

// File: tb/test_wm_burst_arb.sv
`timescale 1ns/1ps
module test_wm_burst_arb;
  localparam int NCH = 4, DW = 32, AW = 32, DEPTH = 16, MAX_BURST = 8;
  localparam int CW = 2, BLW = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCH-1:0]    in_valid = '0;
  logic [NCH-1:0]    in_ready;
  logic [NCH*DW-1:0] in_data = '0;
  logic [BLW-1:0]    cfg_burst_len = '0;
  logic [AW-1:0]     cfg_region_bytes = 32'h1000;
  logic [NCH*AW-1:0] cfg_base;
  logic              out_valid, out_last;
  logic              out_ready = 1'b0;
  logic [DW-1:0]     out_data;
  logic [AW-1:0]     out_addr;
  logic [CW-1:0]     out_chan;

  always #2.5 clk = ~clk;

  wm_burst_arb #(.NCH(NCH), .DW(DW), .AW(AW), .DEPTH(DEPTH), .MAX_BURST(MAX_BURST)) i_wm_burst_arb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cfg_burst_len(cfg_burst_len), .cfg_region_bytes(cfg_region_bytes), .cfg_base(cfg_base),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .out_addr(out_addr), .out_chan(out_chan)
  );

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] model [NCH][64];
  int hd [NCH];
  int tl [NCH];
  logic [AW-1:0] exp_wptr [NCH];
  int exp_rr = 0;
  int seq = 0;

  function automatic logic [AW-1:0] base_of(int ch);
    return 32'h1000_0000 + AW'(ch) * 32'h0100_0000;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic push_n(input int ch, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid[ch] = 1'b1;
      in_data[ch*DW +: DW] = {8'(ch), 24'(seq)};
      if (in_ready[ch]) begin
        model[ch][tl[ch] % 64] = {8'(ch), 24'(seq)};
        tl[ch]++;
      end
      seq++;
    end
    @(negedge clk);
    in_valid[ch] = 1'b0;
  endtask

  task automatic wait_valid(output bit ok);
    int t = 0;
    while (!out_valid && t < 300) begin
      @(negedge clk);
      t++;
    end
    ok = out_valid;
  endtask

  task automatic expect_idle(input int cycles, input string tag);
    repeat (cycles) @(negedge clk);
    check(tag, 64'(out_valid), 64'd0);
  endtask

  // collect one burst and compare every beat
  task automatic get_burst(input int ch, input int len, input logic [AW-1:0] region, input bit stall);
    bit ok;
    logic [AW-1:0] nxt;
    logic [DW-1:0] s_data;
    logic [AW-1:0] s_addr;
    for (int i = 0; i < len; i++) begin
      wait_valid(ok);
      if (!ok) begin
        check("R3 beat missing", 64'd0, 64'd1);
        return;
      end
      check("R4 R7 granted channel", 64'(out_chan), 64'(ch));
      check("R3 beat data order", 64'(out_data), 64'(model[ch][hd[ch] % 64]));
      check("R6 burst address", 64'(out_addr), 64'(base_of(ch) + exp_wptr[ch]));
      check("R3 last flag", 64'(out_last), 64'(i == len - 1));
      if (stall && i == 0) begin
        s_data = out_data;
        s_addr = out_addr;
        repeat (3) @(negedge clk);
        check("R5 valid held in stall", 64'(out_valid), 64'd1);
        check("R5 data held in stall", 64'(out_data), 64'(s_data));
        check("R5 addr held in stall", 64'(out_addr), 64'(s_addr));
      end
      hd[ch]++;
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    nxt = exp_wptr[ch] + AW'(len * (DW / 8));
    exp_wptr[ch] = (nxt >= region) ? '0 : nxt;
    exp_rr = (ch + 1) % NCH;
  endtask

  task automatic t_reset();
    check("R1 output idle after reset", 64'(out_valid), 64'd0);
    check("R1 buffers empty after reset", 64'(in_ready), 64'hF);
  endtask

  task automatic t_watermark();
    cfg_burst_len = 4'd4;
    push_n(1, 3);
    expect_idle(20, "R2 below watermark no burst");
    push_n(1, 1);
    get_burst(1, 4, cfg_region_bytes, 1'b0);
    expect_idle(10, "R2 idle after drain");
  endtask

  task automatic t_disabled();
    cfg_burst_len = 4'd0;
    push_n(2, 5);
    expect_idle(20, "R2 zero length disables");
  endtask

  task automatic t_round_robin();
    push_n(0, 8);
    push_n(1, 8);
    push_n(2, 3);
    push_n(3, 8);
    @(negedge clk);
    cfg_burst_len = 4'd4;
    for (int k = 0; k < 8; k++) begin
      get_burst(exp_rr, 4, cfg_region_bytes, k == 2);
    end
    expect_idle(10, "R7 all channels drained");
  endtask

  task automatic t_wrap();
    @(negedge clk);
    cfg_region_bytes = 32'd48;
    push_n(0, 8);
    get_burst(0, 4, 32'd48, 1'b0);
    get_burst(0, 4, 32'd48, 1'b0);
    check("R6 offset wrapped to zero then advanced", 64'(exp_wptr[0]), 64'd16);
  endtask

  task automatic t_cfg_change();
    bit ok;
    @(negedge clk);
    cfg_region_bytes = 32'h1000;
    cfg_burst_len = 4'd0;
    push_n(3, 4);
    cfg_burst_len = 4'd4;
    wait_valid(ok);
    check("R8 burst granted", 64'(ok), 64'd1);
    cfg_burst_len = 4'd2;
    cfg_region_bytes = 32'd16;
    get_burst(3, 4, 32'h1000, 1'b1);
    push_n(3, 2);
    get_burst(3, 2, 32'd16, 1'b0);
    expect_idle(10, "R8 new length applied at next grant");
  endtask

  task automatic t_full();
    @(negedge clk);
    cfg_region_bytes = 32'h1000;
    cfg_burst_len = 4'd0;
    push_n(1, 16);
    check("R9 ready low when full", 64'(in_ready[1]), 64'd0);
    push_n(1, 1);
    cfg_burst_len = 4'd8;
    get_burst(1, 8, 32'h1000, 1'b0);
    get_burst(1, 8, 32'h1000, 1'b0);
    expect_idle(20, "R9 overflow word not stored");
    check("R9 ready high after drain", 64'(in_ready[1]), 64'd1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      cfg_base[c*AW +: AW] = base_of(c);
      hd[c] = 0;
      tl[c] = 0;
      exp_wptr[c] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_watermark();
    t_disabled();
    t_round_robin();
    t_wrap();
    t_cfg_change();
    t_full();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R3: actual run still active, expected completion");
    finish_run();
  end
endmodule